// File: doc/BRIEF.md
# Cross trigger controller

This block is the per-core end of a cross-triggering network. Debug events from the core and its neighbours (input trigger lines) and pulses that software writes over a small register bus become events on a handful of event channels. Those channel events then drive output trigger lines toward the core, such as a halt request or a restart request. Which inputs feed which channels, and which channels fire which outputs, is set by one mapping register per trigger line.

Each channel also has a gate bit that joins it to a shared matrix outside the block. Through a gated channel, local events are sent out and events from other cores are taken in. One software pulse can therefore halt or restart several cores in the same cycle. An output trigger latches when it fires. It stays high until software writes an acknowledge. Software can poll a status register to see the trigger levels before it raises the next event.

The bus is word addressed with byte offsets. A write takes effect at the clock edge that samples it. Read data is returned one cycle after the read strobe.

Top module: `xtrig_ctrl`

## Requirements
- R1: After reset all mapping, gate and enable registers are 0, every output trigger and channel-out line is low, and every read returns 0.
- R2: Bit 0 of the control register (byte offset 0x000) enables the unit and reads back as the only implemented bit. While it is 0, no input trigger, pulse or incoming channel event sets an output trigger or drives a channel-out line.
- R3: The gate register (offset 0x140) holds one bit per channel. Channel c is driven on chan_out and accepted from chan_in only when gate bit c is 1. Otherwise the channel stays local.
- R4: Input-enable register n (offset 0x020 + 4n), bit c: in any cycle where trig_in[n] is high and the unit is enabled, this raises an event on channel c.
- R5: Output-enable register n (offset 0x0A0 + 4n), bit c: a channel event on channel c sets trig_out[n] at the next clock edge.
- R6: A write to the pulse register (offset 0x01C) raises an event on each channel whose data bit is 1, for the one cycle after the write. Reads of this offset return 0.
- R7: Once set, an output trigger stays high whatever further events arrive, until it is acknowledged.
- R8: Writing 1 to bit n of the acknowledge register (offset 0x010) clears trig_out[n] at the edge that samples the write. If a mapped event occurs in that same cycle, the trigger stays set. Reads of this offset return 0.
- R9: The status register (offset 0x134) reads bit n as the current level of trig_out[n].
- R10: A pulse on chan_in[c], with gate bit c set, sets every output trigger whose output-enable register maps channel c, at the next edge.
- R11: Read data appears one cycle after rd is sampled. Mapping registers read back only their NCH implemented bits. Unmapped offsets read 0.
- R12: chan_out[c] is registered, high for the cycle after a local event (input trigger or pulse) on gated channel c. Events taken in from chan_in are never sent back out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | AW (12) | Byte offset of the register, low two bits ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| trig_in | input | NIN (8) | Input trigger lines, level sampled every cycle |
| trig_out | output | NOUT (8) | Latched output trigger lines |
| chan_in | input | NCH (4) | Single-cycle channel events from the matrix |
| chan_out | output | NCH (4) | Single-cycle channel events to the matrix |

## Verification
Every result arrives a fixed number of edges after its cause. An input trigger or chan_in pulse held for one cycle sets trig_out and chan_out at the edge that samples it. A pulse write first loads a one-cycle pulse register, so trig_out and chan_out follow one edge after the write. An acknowledge clears trig_out at its own write edge, and read data follows the read edge. The bench drives inputs and samples outputs on falling edges. Each task waits exactly the number of falling edges these counts give before it checks. For the pulse, it checks again one edge later to confirm the channel-out line fell.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
   // Word indices (byte offset / 4) of the implemented registers
   localparam int W_CTRL   = 'h000 / 4;
   localparam int W_ACK    = 'h010 / 4;
   localparam int W_PULSE  = 'h01C / 4;
   localparam int W_INEN   = 'h020 / 4;
   localparam int W_OUTEN  = 'h0A0 / 4;
   localparam int W_STATUS = 'h134 / 4;
   localparam int W_GATE   = 'h140 / 4;
   localparam int DATA_W   = 32;
   localparam int MAX_LINES = 32;
endpackage

// File: rtl/xtrig_regs.sv
module xtrig_regs
   import xtrig_pkg::*;
#(
   parameter int NCH  = 4,
   parameter int NIN  = 8,
   parameter int NOUT = 8,
   parameter int AW   = 12
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_i,
   input  logic                           rd_i,
   input  logic [AW-1:0]                  addr_i,
   input  logic [DATA_W-1:0]              wdata_i,
   input  logic [NOUT-1:0]                status_i,
   output logic [DATA_W-1:0]              rdata_o,
   output logic                           en_o,
   output logic [NCH-1:0]                 gate_o,
   output logic [NIN-1:0][NCH-1:0]        inen_o,
   output logic [NOUT-1:0][NCH-1:0]       outen_o,
   output logic [NCH-1:0]                 pulse_o,
   output logic [NOUT-1:0]                ack_o
);
   localparam int WW = AW - 2;

   logic [WW-1:0]     word;
   logic [DATA_W-1:0] rd_val;
   logic              hit_pulse;

   assign word      = addr_i[AW-1:2];
   assign hit_pulse = wr_i && (word == WW'(W_PULSE));
   assign ack_o     = (wr_i && (word == WW'(W_ACK))) ? wdata_i[NOUT-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o    <= 1'b0;
         gate_o  <= '0;
         inen_o  <= '0;
         outen_o <= '0;
         pulse_o <= '0;
      end else begin
         pulse_o <= hit_pulse ? wdata_i[NCH-1:0] : '0;
         if (wr_i) begin
            if (word == WW'(W_CTRL)) en_o   <= wdata_i[0];
            if (word == WW'(W_GATE)) gate_o <= wdata_i[NCH-1:0];
            for (int n = 0; n < NIN; n++)
               if (word == WW'(W_INEN + n)) inen_o[n] <= wdata_i[NCH-1:0];
            for (int n = 0; n < NOUT; n++)
               if (word == WW'(W_OUTEN + n)) outen_o[n] <= wdata_i[NCH-1:0];
         end
      end
   end

   always_comb begin
      rd_val = '0;
      if (word == WW'(W_CTRL))   rd_val = DATA_W'(en_o);
      if (word == WW'(W_GATE))   rd_val = DATA_W'(gate_o);
      if (word == WW'(W_STATUS)) rd_val = DATA_W'(status_i);
      for (int n = 0; n < NIN; n++)
         if (word == WW'(W_INEN + n)) rd_val = DATA_W'(inen_o[n]);
      for (int n = 0; n < NOUT; n++)
         if (word == WW'(W_OUTEN + n)) rd_val = DATA_W'(outen_o[n]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_o <= '0;
      else        rdata_o <= rd_i ? rd_val : '0;
   end

   // R9: status read returns the trigger levels seen at the read edge
   a_r9_status_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && word == WW'(W_STATUS)) |=> rdata_o == DATA_W'($past(status_i)));
   // R6: the pulse register is write-only
   a_r6_pulse_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && word == WW'(W_PULSE)) |=> rdata_o == '0);
   // R8: the acknowledge register is write-only
   a_r8_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && word == WW'(W_ACK)) |=> rdata_o == '0);
endmodule

// File: rtl/xtrig_route.sv
module xtrig_route #(
   parameter int NCH  = 4,
   parameter int NIN  = 8,
   parameter int NOUT = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en_i,
   input  logic [NCH-1:0]           gate_i,
   input  logic [NIN-1:0][NCH-1:0]  inen_i,
   input  logic [NOUT-1:0][NCH-1:0] outen_i,
   input  logic [NIN-1:0]           trig_in_i,
   input  logic [NCH-1:0]           pulse_i,
   input  logic [NCH-1:0]           chan_in_i,
   output logic [NCH-1:0]           chan_out_o,
   output logic [NOUT-1:0]          fire_o
);
   logic [NCH-1:0] loc_ev;
   logic [NCH-1:0] all_ev;

   always_comb begin
      loc_ev = pulse_i;
      for (int n = 0; n < NIN; n++)
         if (trig_in_i[n]) loc_ev = loc_ev | inen_i[n];
      if (!en_i) loc_ev = '0;
   end

   assign all_ev = en_i ? (loc_ev | (chan_in_i & gate_i)) : '0;

   for (genvar n = 0; n < NOUT; n++) begin : g_fire
      assign fire_o[n] = |(all_ev & outen_i[n]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chan_out_o <= '0;
      else        chan_out_o <= loc_ev & gate_i;
   end

   // R2: a disabled unit sends nothing to the matrix
   a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> chan_out_o == '0);
   // R3: only gated channels reach the matrix
   a_r3_gate_out: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_out_o & ~$past(gate_i)) == '0);
   // R12: without a local source nothing is sent, whatever arrives on chan_in
   a_r12_no_echo: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_i == '0 && trig_in_i == '0) |=> chan_out_o == '0);
endmodule

// File: rtl/xtrig_latch.sv
module xtrig_latch #(
   parameter int NOUT = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NOUT-1:0] fire_i,
   input  logic [NOUT-1:0] ack_i,
   output logic [NOUT-1:0] trig_o
);
   for (genvar n = 0; n < NOUT; n++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         trig_o[n] <= 1'b0;
         else if (fire_i[n]) trig_o[n] <= 1'b1;
         else if (ack_i[n])  trig_o[n] <= 1'b0;
      end

      // R5: a mapped event sets the trigger at the next edge
      a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
         fire_i[n] |=> trig_o[n]);
      // R7: a set trigger holds until acknowledged
      a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_o[n] && !ack_i[n]) |=> trig_o[n]);
      // R8: a trigger only falls after an acknowledge
      a_r8_clear_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(trig_o[n]) |-> $past(ack_i[n]));
   end
endmodule

// File: rtl/xtrig_ctrl.sv
module xtrig_ctrl
   import xtrig_pkg::*;
#(
   parameter int NCH  = 4,
   parameter int NIN  = 8,
   parameter int NOUT = 8,
   parameter int AW   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [AW-1:0]     reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NIN-1:0]    trig_in,
   output logic [NOUT-1:0]   trig_out,
   input  logic [NCH-1:0]    chan_in,
   output logic [NCH-1:0]    chan_out
);
   if (NCH < 1 || NCH > MAX_LINES) begin : g_bad_nch
      $error("NCH must lie in 1..32");
   end
   if (NIN < 1 || NIN > MAX_LINES) begin : g_bad_nin
      $error("NIN must lie in 1..32");
   end
   if (NOUT < 1 || NOUT > MAX_LINES) begin : g_bad_nout
      $error("NOUT must lie in 1..32");
   end
   if (AW < 9) begin : g_bad_aw
      $error("AW must reach offset 0x140");
   end

   logic                     en;
   logic [NCH-1:0]           gate;
   logic [NIN-1:0][NCH-1:0]  inen;
   logic [NOUT-1:0][NCH-1:0] outen;
   logic [NCH-1:0]           pulse;
   logic [NOUT-1:0]          ack;
   logic [NOUT-1:0]          fire;

   xtrig_regs #(.NCH(NCH), .NIN(NIN), .NOUT(NOUT), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .rd_i(reg_rd),
      .addr_i(reg_addr), .wdata_i(reg_wdata), .status_i(trig_out),
      .rdata_o(reg_rdata), .en_o(en), .gate_o(gate), .inen_o(inen),
      .outen_o(outen), .pulse_o(pulse), .ack_o(ack)
   );

   xtrig_route #(.NCH(NCH), .NIN(NIN), .NOUT(NOUT)) u_route (
      .clk(clk), .rst_n(rst_n), .en_i(en), .gate_i(gate), .inen_i(inen),
      .outen_i(outen), .trig_in_i(trig_in), .pulse_i(pulse),
      .chan_in_i(chan_in), .chan_out_o(chan_out), .fire_o(fire)
   );

   xtrig_latch #(.NOUT(NOUT)) u_latch (
      .clk(clk), .rst_n(rst_n), .fire_i(fire), .ack_i(ack), .trig_o(trig_out)
   );

   // R10: an accepted incoming event on a mapped channel sets a trigger
   a_r10_remote_set: assert property (@(posedge clk) disable iff (!rst_n)
      (en && |(chan_in & gate & outen[0])) |=> trig_out[0]);
endmodule

// File: tb/xtrig_ctrl_bench.sv
`timescale 1ns/1ps
module xtrig_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [7:0]  trig_in = '0;
   logic [7:0]  trig_out;
   logic [3:0]  chan_in = '0;
   logic [3:0]  chan_out;
   int n_chk = 0, n_fail = 0;
   logic [31:0] rv;

   always #4 clk = ~clk;

   xtrig_ctrl u_xtrig_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .trig_in(trig_in),
      .trig_out(trig_out), .chan_in(chan_in), .chan_out(chan_out)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wreg(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rreg(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); rd = 1'b1; addr = a;
      @(negedge clk); d = rdata; rd = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 trig_out in reset", 32'(trig_out), 0);
      chk("R1 chan_out in reset", 32'(chan_out), 0);
      @(negedge clk); rst_n = 1'b1;
      rreg(12'h000, rv); chk("R1 ctrl reset", rv, 0);
      rreg(12'h140, rv); chk("R1 gate reset", rv, 0);
      rreg(12'h0A0, rv); chk("R1 outen0 reset", rv, 0);
      rreg(12'h134, rv); chk("R1 status reset", rv, 0);
   endtask

   task automatic t_disabled;
      wreg(12'h0A0, 32'h4);
      wreg(12'h140, 32'hF);
      wreg(12'h01C, 32'h4);
      @(negedge clk);
      chk("R2 no trigger while off", 32'(trig_out), 0);
      chk("R2 no chan_out while off", 32'(chan_out), 0);
      @(negedge clk); chan_in = 4'h4;
      @(negedge clk); chan_in = 4'h0;
      chk("R2 chan_in ignored while off", 32'(trig_out), 0);
   endtask

   task automatic t_enable;
      wreg(12'h000, 32'hFFFF_FFFF);
      rreg(12'h000, rv); chk("R2 ctrl reads bit0 only", rv, 1);
      wreg(12'h140, 32'h0);
   endtask

   task automatic t_local_pulse;
      wreg(12'h01C, 32'h4);
      chk("R6 no effect at write edge", 32'(trig_out), 0);
      @(negedge clk);
      chk("R5 trig_out0 from channel 2", 32'(trig_out), 32'h01);
      chk("R3 ungated pulse stays local", 32'(chan_out), 0);
      rreg(12'h134, rv); chk("R9 status shows trigger", rv, 32'h01);
      rreg(12'h01C, rv); chk("R6 pulse reg reads 0", rv, 0);
   endtask

   task automatic t_hold_ack;
      wreg(12'h01C, 32'h4);
      @(negedge clk); @(negedge clk);
      chk("R7 trigger held", 32'(trig_out), 32'h01);
      wreg(12'h010, 32'h1);
      chk("R8 ack clears", 32'(trig_out), 0);
      rreg(12'h010, rv); chk("R8 ack reg reads 0", rv, 0);
      rreg(12'h134, rv); chk("R9 status after ack", rv, 0);
   endtask

   task automatic t_gated_pulse;
      wreg(12'h140, 32'h4);
      wreg(12'h01C, 32'h4);
      @(negedge clk);
      chk("R12 chan_out from pulse", 32'(chan_out), 32'h4);
      @(negedge clk);
      chk("R6 chan_out one cycle only", 32'(chan_out), 0);
      wreg(12'h010, 32'hFF);
   endtask

   task automatic t_input_trig;
      wreg(12'h020 + 12'd12, 32'h2);
      wreg(12'h0A0 + 12'd20, 32'h2);
      wreg(12'h140, 32'h2);
      @(negedge clk); trig_in = 8'h08;
      @(negedge clk); trig_in = 8'h00;
      chk("R4 trig_in3 fires output 5", 32'(trig_out), 32'h20);
      chk("R12 trig_in event to matrix", 32'(chan_out), 32'h2);
      @(negedge clk);
      chk("R12 chan_out falls", 32'(chan_out), 0);
      wreg(12'h010, 32'h20);
      chk("R8 ack output 5", 32'(trig_out), 0);
   endtask

   task automatic t_remote;
      wreg(12'h0A4, 32'h2);
      @(negedge clk); chan_in = 4'h2;
      @(negedge clk); chan_in = 4'h0;
      chk("R10 remote event fires 1 and 5", 32'(trig_out), 32'h22);
      chk("R12 no echo of chan_in", 32'(chan_out), 0);
      wreg(12'h010, 32'h22);
      wreg(12'h140, 32'h0);
      @(negedge clk); chan_in = 4'h2;
      @(negedge clk); chan_in = 4'h0;
      chk("R3 ungated chan_in ignored", 32'(trig_out), 0);
   endtask

   task automatic t_ack_race;
      wreg(12'h0A0, 32'h1);
      wreg(12'h140, 32'h1);
      @(negedge clk); chan_in = 4'h1;
      @(negedge clk); chan_in = 4'h0;
      chk("R10 trigger 0 set", 32'(trig_out[0]), 1);
      @(negedge clk); wr = 1'b1; addr = 12'h010; wdata = 32'h1; chan_in = 4'h1;
      @(negedge clk); wr = 1'b0; chan_in = 4'h0;
      chk("R8 event beats ack", 32'(trig_out[0]), 1);
      wreg(12'h010, 32'h1);
      chk("R8 plain ack clears", 32'(trig_out[0]), 0);
   endtask

   task automatic t_readback;
      rreg(12'h02C, rv); chk("R11 inen3 readback", rv, 32'h2);
      wreg(12'h020, 32'hFFFF_FFFF);
      rreg(12'h020, rv); chk("R11 inen0 width", rv, 32'hF);
      wreg(12'h0BC, 32'h9);
      rreg(12'h0BC, rv); chk("R11 outen7 readback", rv, 32'h9);
      rreg(12'h200, rv); chk("R11 unmapped reads 0", rv, 0);
      wreg(12'h000, 32'h0);
      @(negedge clk); trig_in = 8'h01;
      @(negedge clk); trig_in = 8'h00;
      chk("R2 trig_in ignored after disable", 32'(trig_out), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_disabled();
      t_enable();
      t_local_pulse();
      t_hold_ack();
      t_gated_pulse();
      t_input_trig();
      t_remote();
      t_ack_race();
      t_readback();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule